// File: doc/BRIEF.md
# Dual-Channel Converter Serial Read Port

This block is the device side of the serial read port of a dual-channel 12-bit converter. A host drives an active-low select and a serial clock. The block drives two data lines, each with an output-enable flag that stands in for a three-state driver, and a track/hold status flag. Both select and serial clock are brought into the local clock domain through synchronizers, and their edges are detected there. On the select falling edge the block latches the two 12-bit results from its parallel inputs, enables both lines and enters hold. It then shifts each result out MSB first. Each result is framed by two leading zeros and, in the long frame mode, by two trailing zeros.

If select stays low after the first frame, each line goes on to stream the other channel's result: line A carries channel B, and line B carries channel A. Both lines stop driving on the 32nd serial clock falling edge, or earlier when select rises. The `frame16` input picks the frame length (14 or 16 clocks) and is latched at select assertion. The conversion results come from ports, so the analog side is modelled only through the hold flag.

Top module: `adc_dual_serout`

## Requirements
- R1: After reset, and whenever select is high, `oe_a`, `oe_b` and `hold` are 0.
- R2: A select falling edge sets `oe_a`, `oe_b` and `hold` to 1. Both lines then drive 0, which is the first leading zero, before any serial clock falling edge.
- R3: The block counts serial clock falling edges after select falls. After falling edge k, a line drives a leading zero for k = 0 and k = 1. For k = 2 to 13 it drives bit 13-k of its own result, so DB11 appears at k = 2 and DB0 at k = 13.
- R4: With `frame16` = 1 latched, the line drives 0 at k = 14 and k = 15, which are the trailing zeros.
- R5: Let F be 14 (`frame16` = 0) or 16 (`frame16` = 1). For F ≤ k < 32, line A drives the value that the R3/R4 mapping gives for index k-F applied to channel B's result, and line B does the same with channel A's result. Any index at or beyond F gives 0.
- R6: From falling edge 32 on, `oe_a` and `oe_b` are 0. Further falling edges change nothing until select rises.
- R7: A select rising edge clears `oe_a`, `oe_b` and `hold` at any bit count.
- R8: `hold` returns to 0 on the first serial clock rising edge that follows the 13th falling edge. It stays 1 through every earlier rising edge.
- R9: A serial clock falling edge that coincides with the select falling edge is not counted.
- R10: A serial clock rising edge before the first falling edge leaves the outputs and `hold` unchanged.
- R11: The results and `frame16` are captured at the select falling edge. Later changes on those inputs have no effect on the lines until the next select falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that samples the host signals |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| frame16 | input | 1 | 1 selects 16-clock frames with trailing zeros, 0 selects 14-clock frames |
| res_a | input | 12 | Channel A conversion result |
| res_b | input | 12 | Channel B conversion result |
| dout_a | output | 1 | Line A data bit |
| oe_a | output | 1 | Line A drive enable (0 = high impedance) |
| dout_b | output | 1 | Line B data bit |
| oe_b | output | 1 | Line B drive enable (0 = high impedance) |
| hold | output | 1 | 1 while the sample is held, 0 while tracking |

## Verification
Full 34-clock extended reads are run for eight result pairs in both frame modes. The pairs include all zeros, all ones, alternating bits, and single set bits at the MSB and the LSB. Together they separate an off-by-one bit index, a missing or misplaced trailing zero, a wrong channel swap and a wrong cut-off edge, because each line carries a value different from its partner. The result inputs are altered in the middle of each read to show that they were latched. Dedicated runs cover an early select release, a serial clock fall that coincides with select assertion, and a rising edge before the first fall.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;
    localparam int RES_W     = 12;
    localparam int LEAD_Z    = 2;
    localparam int TRAIL_Z   = 2;
    localparam int SHORT_F   = LEAD_Z + RES_W;
    localparam int LONG_F    = SHORT_F + TRAIL_Z;
    localparam int EXT_LIMIT = 2 * LONG_F;
    localparam int TRACK_AT  = SHORT_F - 1;
    localparam int CNT_W     = $clog2(EXT_LIMIT + 1);

    typedef struct packed {
        logic             active;
        logic             hold;
        logic             long_f;
        logic [CNT_W-1:0] cnt;
        logic [RES_W-1:0] word_a;
        logic [RES_W-1:0] word_b;
    } port_state_t;
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q, chain_d;
    logic              prev_q, prev_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
        prev_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = chain_q[STAGES-1] & ~prev_q;
    assign fall  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/adc_frame_bit.sv
module adc_frame_bit
    import adc_ser_pkg::*;
(
    input  logic [CNT_W-1:0] cnt,
    input  logic             long_f,
    input  logic [RES_W-1:0] own_word,
    input  logic [RES_W-1:0] other_word,
    output logic             bit_o
);
    int               frame_len;
    int               idx;
    logic [RES_W-1:0] word;

    always_comb begin
        frame_len = long_f ? LONG_F : SHORT_F;
        bit_o     = 1'b0;
        if (int'(cnt) < frame_len) begin
            idx  = int'(cnt);
            word = own_word;
        end else begin
            idx  = int'(cnt) - frame_len;
            word = other_word;
        end
        if (int'(cnt) < EXT_LIMIT && idx < frame_len &&
            idx >= LEAD_Z && idx < LEAD_Z + RES_W) begin
            bit_o = word[RES_W - 1 - (idx - LEAD_Z)];
        end
    end
endmodule

// File: rtl/adc_dual_serout.sv
module adc_dual_serout
    import adc_ser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             frame16,
    input  logic [RES_W-1:0] res_a,
    input  logic [RES_W-1:0] res_b,
    output logic             dout_a,
    output logic             oe_a,
    output logic             dout_b,
    output logic             oe_b,
    output logic             hold
);
    port_state_t st_q, st_d;
    logic cs_lvl, cs_rise, cs_fall;
    logic sc_lvl, sc_rise, sc_fall;
    logic [1:0] bits;

    adc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) cs_sync_i (
        .clk(clk), .rst_n(rst_n), .din(cs_n),
        .level(cs_lvl), .rise(cs_rise), .fall(cs_fall)
    );

    adc_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) sc_sync_i (
        .clk(clk), .rst_n(rst_n), .din(sclk),
        .level(sc_lvl), .rise(sc_rise), .fall(sc_fall)
    );

    // Line A sends A then B; line B sends B then A.
    for (genvar ch = 0; ch < 2; ch++) begin : g_line
        adc_frame_bit bit_i (
            .cnt       (st_q.cnt),
            .long_f    (st_q.long_f),
            .own_word  (ch == 0 ? st_q.word_a : st_q.word_b),
            .other_word(ch == 0 ? st_q.word_b : st_q.word_a),
            .bit_o     (bits[ch])
        );
    end

    always_comb begin
        st_d = st_q;
        if (cs_fall) begin
            // A clock fall seen in this same cycle is dropped.
            st_d.active = 1'b1;
            st_d.hold   = 1'b1;
            st_d.cnt    = '0;
            st_d.long_f = frame16;
            st_d.word_a = res_a;
            st_d.word_b = res_b;
        end else if (cs_rise) begin
            st_d.active = 1'b0;
            st_d.hold   = 1'b0;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (sc_fall && int'(st_q.cnt) != EXT_LIMIT) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (sc_rise && int'(st_q.cnt) >= TRACK_AT) begin
                st_d.hold = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic drive;
    assign drive  = st_q.active & (int'(st_q.cnt) < EXT_LIMIT);
    assign oe_a   = drive;
    assign oe_b   = drive;
    assign dout_a = drive & bits[0];
    assign dout_b = drive & bits[1];
    assign hold   = st_q.hold;

    // R6
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) <= EXT_LIMIT);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active && !cs_rise && !cs_fall |=>
            (st_q.cnt == $past(st_q.cnt)) || (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R11
    word_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_fall |=> $stable(st_q.word_a) && $stable(st_q.word_b) && $stable(st_q.long_f));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl && !cs_fall |=> !oe_a && !oe_b && !hold);

    // R8
    track_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> $past(sc_rise) || $past(cs_rise));

    // R2
    sel_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> oe_a && oe_b && hold && !dout_a && !dout_b);

    // R6
    sc_level_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) == EXT_LIMIT && !cs_rise |=> !oe_a && !oe_b);

    logic unused_lvl;
    assign unused_lvl = sc_lvl;
endmodule

// File: tb/adc_dual_serout_tb.sv
module adc_dual_serout_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        frame16 = 1'b0;
    logic [11:0] res_a = '0;
    logic [11:0] res_b = '0;
    logic        dout_a, oe_a, dout_b, oe_b, hold;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    adc_dual_serout dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .frame16(frame16),
        .res_a(res_a), .res_b(res_b), .dout_a(dout_a), .oe_a(oe_a),
        .dout_b(dout_b), .oe_b(oe_b), .hold(hold)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic exp_bit(int k, bit f16, logic [11:0] own, logic [11:0] oth);
        int f = f16 ? 16 : 14;
        int idx;
        logic [11:0] w;
        if (k >= 32) return 1'b0;
        if (k < f) begin idx = k; w = own; end
        else begin idx = k - f; w = oth; if (idx >= f) return 1'b0; end
        if (idx >= 2 && idx < 14) return w[13 - idx];
        return 1'b0;
    endfunction

    task automatic full_read(input logic [11:0] a, input logic [11:0] b, input bit f16);
        string tag;
        res_a = a; res_b = b; frame16 = f16;
        sclk = 1'b0;
        settle();
        cs_n = 1'b0;
        settle();
        chk("R2 oe_a", oe_a, 1'b1);
        chk("R2 oe_b", oe_b, 1'b1);
        chk("R2 hold", hold, 1'b1);
        chk("R2 dout_a", dout_a, 1'b0);
        res_a = ~a; res_b = ~b; frame16 = ~f16;
        sclk = 1'b1;
        settle();
        chk("R10 hold", hold, 1'b1);
        chk("R10 dout_b", dout_b, 1'b0);
        for (int k = 1; k <= 34; k++) begin
            sclk = 1'b0;
            settle();
            if (k < 14) tag = "R3";
            else if (k < (f16 ? 16 : 14)) tag = "R4";
            else if (k < 32) tag = "R5";
            else tag = "R6";
            chk({tag, " oe_a"}, oe_a, k < 32);
            chk({tag, " oe_b"}, oe_b, k < 32);
            chk({tag, "/R11 dout_a"}, dout_a, exp_bit(k, f16, a, b));
            chk({tag, "/R11 dout_b"}, dout_b, exp_bit(k, f16, b, a));
            chk("R8 hold", hold, k <= 13);
            sclk = 1'b1;
            settle();
        end
        cs_n = 1'b1;
        settle();
        chk("R7 oe_a", oe_a, 1'b0);
        chk("R7 hold", hold, 1'b0);
    endtask

    initial begin
        logic [11:0] pats [8];
        pats[0] = 12'h000; pats[1] = 12'hFFF; pats[2] = 12'hA5A; pats[3] = 12'h5A5;
        pats[4] = 12'h800; pats[5] = 12'h001; pats[6] = 12'h3C7; pats[7] = 12'hE18;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 oe_a reset", oe_a, 1'b0);
        chk("R1 oe_b reset", oe_b, 1'b0);
        chk("R1 hold reset", hold, 1'b0);
        rst_n = 1'b1;
        settle();
        chk("R1 oe_a idle", oe_a, 1'b0);

        for (int i = 0; i < 8; i++) begin
            for (int f = 0; f < 2; f++) begin
                full_read(pats[i], {pats[i][5:0], pats[i][11:6]} ^ 12'h249, f[0]);
            end
        end

        // R7: early release after 9 falls
        res_a = 12'hFFF; res_b = 12'hFFF; frame16 = 1'b0;
        cs_n = 1'b0; settle();
        for (int k = 1; k <= 9; k++) begin
            sclk = 1'b1; settle(); sclk = 1'b0; settle();
        end
        chk("R7 mid-frame dout_a", dout_a, 1'b1);
        cs_n = 1'b1; settle();
        chk("R7 early oe_a", oe_a, 1'b0);
        chk("R7 early oe_b", oe_b, 1'b0);
        chk("R7 early hold", hold, 1'b0);

        // R9: clock fall together with select fall
        res_a = 12'h800; res_b = 12'h000;
        sclk = 1'b1; settle();
        cs_n = 1'b0; sclk = 1'b0; settle();
        chk("R9 dout_a at k0", dout_a, 1'b0);
        sclk = 1'b1; settle(); sclk = 1'b0; settle();
        chk("R9 dout_a at k1", dout_a, 1'b0);
        sclk = 1'b1; settle(); sclk = 1'b0; settle();
        chk("R9 dout_a at k2 (DB11)", dout_a, 1'b1);
        sclk = 1'b1; settle(); sclk = 1'b0; settle();
        chk("R9 dout_a at k3 (DB10)", dout_a, 1'b0);
        cs_n = 1'b1; settle();
        chk("R1 idle after", oe_a, 1'b0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule